// File: doc/BRIEF.md
# Nibble Memory Shift-Right Execution Unit

This unit carries out the one-bit logical right shift of a 4-bit data-memory location for a small 4-bit processor. It receives an instruction word with a start strobe, reads the nibble that an index register (X or Y) points to, and writes back that nibble shifted right with a zero in the top bit. The bit shifted out goes to the carry flag. The whole sequence is a fixed two-cycle read-modify-write on a simple memory port. In its second cycle the unit returns the updated flags. For the post-increment forms it also returns a write-back of the index register, advanced by one.

A preceding extension-load instruction, which is outside this block, leaves the extension flag set and an 8-bit page offset in the extension register. For the plain forms this overrides the address: the X form goes to a location in the lowest 256-nibble page, and the Y form goes to a location in the highest page. The post-increment forms ignore the override. Every form clears the extension flag on completion. An instruction word that is not one of the four shift encodings does not start an access; it raises an illegal-opcode indication instead.

Top module: `nshift_exec`

## Requirements
- R1: The unit accepts exactly the four encodings 0x10E4 (shift at X), 0x10E5 (shift at X, then increment X), 0x10E6 (shift at Y) and 0x10E7 (shift at Y, then increment Y). In these encodings bit 1 selects Y and bit 0 selects post-increment. Any other word presented with start while idle raises illegal in that same cycle and causes no memory write, no done and no index write.
- R2: In the cycle that start is accepted (cycle 1), mem_addr carries the target address, mem_we is low, and mem_rdata is sampled at the closing clock edge. In the next cycle (cycle 2), mem_addr carries the same address, mem_we is high and done is high. In the cycle after that, done and mem_we are low again.
- R3: In cycle 2, mem_wdata equals the sampled nibble shifted right by one, with bit 3 equal to 0.
- R4: At done, flag_c_o equals bit 0 of the sampled nibble. flag_z_o is 1 exactly when the written nibble is 0.
- R5: At done, flag_e_o is 0 and flag_i_o equals flag_i as it was at start. When done is low, all four flag outputs echo the flag inputs.
- R6: With flag_e set, the plain X form (0x10E4) addresses 0x0000 + ext_val instead of X.
- R7: With flag_e set, the plain Y form (0x10E6) addresses 0xFF00 + ext_val instead of Y.
- R8: The post-increment forms address the index register itself whether or not flag_e is set.
- R9: At done, a post-increment form asserts idx_we, with idx_sel = 1 for Y and 0 for X, and idx_wdata = index + 1, wrapping from 0xFFFF to 0x0000. A plain form keeps idx_we low. The increment result has no effect on any flag.
- R10: A start presented during cycle 2 is ignored: no second access follows once the operation completes.
- R11: While reset is held, and right after it is released, mem_we, done, idx_we and illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction present this cycle |
| instr | input | 13 | Instruction word |
| idx_x | input | 16 | X index register value |
| idx_y | input | 16 | Y index register value |
| ext_val | input | 8 | Extension register value (page offset) |
| flag_e | input | 1 | Extension flag |
| flag_i | input | 1 | Interrupt flag |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| mem_addr | output | 16 | Data memory address |
| mem_rdata | input | 4 | Data memory read nibble |
| mem_wdata | output | 4 | Data memory write nibble |
| mem_we | output | 1 | Data memory write enable |
| busy | output | 1 | Second cycle in progress |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Unrecognised opcode presented with start |
| flag_e_o | output | 1 | Updated extension flag |
| flag_i_o | output | 1 | Updated interrupt flag |
| flag_c_o | output | 1 | Updated carry flag |
| flag_z_o | output | 1 | Updated zero flag |
| idx_we | output | 1 | Index register write-back enable |
| idx_sel | output | 1 | Index to write: 0 for X, 1 for Y |
| idx_wdata | output | 16 | Incremented index value |

## Verification
The shift is tried with nibbles that have bit 0 set and bit 0 clear, so a swapped or missing carry shows up. It is also tried with 0x1 and 0x0, where the result is zero, against 0xF and 0x8, which show whether the top bit is filled with zero and whether Z follows the result rather than the input. Each of the four encodings is run with the extension flag both clear and set, and with X, Y and the extension offset all distinct. Any mix-up between X, Y, the zero page and the top page, or an override applied to a post-increment form, then gives a distinct wrong address. An index of 0xFFFF with a non-zero nibble checks the wrap, and shows that the zero increment result does not leak into Z. Neighbouring words such as 0x10E3, 0x10E8 and 0x00E4 check that decoding uses the whole word.

// File: rtl/nshift_pkg.sv
package nshift_pkg;

   // Sequencer state: idle accepts an instruction, write is the second cycle
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_WRITE = 1'b1
   } nshift_state_e;

   // Decoded operation variant
   typedef struct packed {
      logic use_y;     // index Y instead of X
      logic post_inc;  // advance the index after the shift
   } nshift_op_t;

endpackage

// File: rtl/nshift_decode.sv
module nshift_decode
   import nshift_pkg::*;
#(
   parameter int             OP_W    = 13,
   parameter logic [OP_W-1:0] OP_BASE = 13'h10E4
)(
   input  logic [OP_W-1:0] instr,
   output logic            valid,
   output nshift_op_t      op
);

   localparam int FAM_LSB = 2;

   // the two low bits pick the variant, so the base must leave them clear
   if (OP_W <= FAM_LSB) begin : g_bad_width
      $error("nshift_decode: OP_W too small");
   end
   if (OP_BASE[FAM_LSB-1:0] != '0) begin : g_bad_base
      $error("nshift_decode: OP_BASE low bits must be zero");
   end

   always_comb begin
      valid       = (instr[OP_W-1:FAM_LSB] == OP_BASE[OP_W-1:FAM_LSB]);
      op.use_y    = instr[1];
      op.post_inc = instr[0];
   end

endmodule

// File: rtl/nshift_addr_gen.sv
module nshift_addr_gen
   import nshift_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int EXT_W      = 8,
   parameter bit EXT_ENABLE = 1'b1
)(
   input  nshift_op_t        op,
   input  logic [ADDR_W-1:0] idx_x,
   input  logic [ADDR_W-1:0] idx_y,
   input  logic [EXT_W-1:0]  ext_val,
   input  logic              flag_e,
   output logic [ADDR_W-1:0] addr
);

   localparam int PAGE_W = ADDR_W - EXT_W;

   if (PAGE_W < 1) begin : g_bad_width
      $error("nshift_addr_gen: ADDR_W must exceed EXT_W");
   end

   logic [ADDR_W-1:0] idx_addr;
   logic [ADDR_W-1:0] page_addr;
   logic              override;

   always_comb begin
      idx_addr  = op.use_y ? idx_y : idx_x;
      // X form lands in the lowest page, Y form in the highest
      page_addr = op.use_y ? {{PAGE_W{1'b1}}, ext_val} : {{PAGE_W{1'b0}}, ext_val};
   end

   if (EXT_ENABLE) begin : g_ext
      // the override is never applied to the post-increment forms
      assign override = flag_e & ~op.post_inc;
   end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = flag_e ^ (^page_addr);
      assign override   = 1'b0;
   end

   assign addr = override ? page_addr : idx_addr;

endmodule

// File: rtl/nshift_alu.sv
module nshift_alu #(
   parameter int DATA_W = 4
)(
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] result,
   output logic              carry,
   output logic              zero
);

   if (DATA_W < 2) begin : g_bad_width
      $error("nshift_alu: DATA_W must be at least 2");
   end

   for (genvar b = 0; b < DATA_W - 1; b++) begin : g_bit
      assign result[b] = operand[b+1];
   end
   assign result[DATA_W-1] = 1'b0;

   assign carry = operand[0];
   assign zero  = (result == '0);

endmodule

// File: rtl/nshift_exec.sv
module nshift_exec
   import nshift_pkg::*;
#(
   parameter int              OP_W    = 13,
   parameter logic [OP_W-1:0] OP_BASE = 13'h10E4,
   parameter int              ADDR_W  = 16,
   parameter int              EXT_W   = 8,
   parameter int              DATA_W  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   instr,
   input  logic [ADDR_W-1:0] idx_x,
   input  logic [ADDR_W-1:0] idx_y,
   input  logic [EXT_W-1:0]  ext_val,
   input  logic              flag_e,
   input  logic              flag_i,
   input  logic              flag_c,
   input  logic              flag_z,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic              flag_e_o,
   output logic              flag_i_o,
   output logic              flag_c_o,
   output logic              flag_z_o,
   output logic              idx_we,
   output logic              idx_sel,
   output logic [ADDR_W-1:0] idx_wdata
);

   localparam logic [ADDR_W-1:0] IDX_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   nshift_state_e     state_q;
   nshift_op_t        dec_op;
   logic              dec_valid;
   logic [ADDR_W-1:0] gen_addr;
   logic              accept;

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] rdata_q;
   logic [ADDR_W-1:0] idx_q;
   nshift_op_t        op_q;
   logic              flag_i_q;

   logic [DATA_W-1:0] alu_res;
   logic              alu_c;
   logic              alu_z;

   nshift_decode #(.OP_W(OP_W), .OP_BASE(OP_BASE)) u_decode (
      .instr (instr),
      .valid (dec_valid),
      .op    (dec_op)
   );

   nshift_addr_gen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .EXT_ENABLE(1'b1)) u_addr (
      .op      (dec_op),
      .idx_x   (idx_x),
      .idx_y   (idx_y),
      .ext_val (ext_val),
      .flag_e  (flag_e),
      .addr    (gen_addr)
   );

   nshift_alu #(.DATA_W(DATA_W)) u_alu (
      .operand (rdata_q),
      .result  (alu_res),
      .carry   (alu_c),
      .zero    (alu_z)
   );

   assign accept  = (state_q == ST_IDLE) & start & dec_valid;
   assign illegal = (state_q == ST_IDLE) & start & ~dec_valid;
   assign busy    = (state_q == ST_WRITE);

   // cycle 1 samples the operand; cycle 2 writes it back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         rdata_q  <= '0;
         idx_q    <= '0;
         op_q     <= '0;
         flag_i_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q  <= ST_WRITE;
                  addr_q   <= gen_addr;
                  rdata_q  <= mem_rdata;
                  idx_q    <= dec_op.use_y ? idx_y : idx_x;
                  op_q     <= dec_op;
                  flag_i_q <= flag_i;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr  = busy ? addr_q : gen_addr;
      mem_wdata = busy ? alu_res : '0;
      mem_we    = busy;
      done      = busy;
      flag_e_o  = busy ? 1'b0     : flag_e;
      flag_i_o  = busy ? flag_i_q : flag_i;
      flag_c_o  = busy ? alu_c    : flag_c;
      flag_z_o  = busy ? alu_z    : flag_z;
      idx_we    = busy & op_q.post_inc;
      idx_sel   = op_q.use_y;
      idx_wdata = idx_q + IDX_ONE;
   end

   // R2
   done_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(accept));
   // R2
   write_addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr == $past(mem_addr)));
   // R2
   single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3
   top_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata[DATA_W-1] == 1'b0));
   // R4
   carry_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_c_o == $past(mem_rdata[0])));
   // R4
   zero_matches_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_z_o == (mem_wdata == '0)));
   // R5
   ext_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !flag_e_o);
   // R1
   illegal_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> !done);
   // R9
   idx_write_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_we |-> done);

endmodule

// File: tb/nshift_exec_tb.sv
module nshift_exec_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [12:0] instr = '0;
   logic [15:0] idx_x = '0, idx_y = '0;
   logic [7:0]  ext_val = '0;
   logic        flag_e = 0, flag_i = 0, flag_c = 0, flag_z = 0;
   logic [15:0] mem_addr;
   logic [3:0]  mem_rdata = '0;
   logic [3:0]  mem_wdata;
   logic        mem_we, busy, done, illegal;
   logic        flag_e_o, flag_i_o, flag_c_o, flag_z_o;
   logic        idx_we, idx_sel;
   logic [15:0] idx_wdata;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   nshift_exec u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .idx_x(idx_x), .idx_y(idx_y), .ext_val(ext_val),
      .flag_e(flag_e), .flag_i(flag_i), .flag_c(flag_c), .flag_z(flag_z),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .busy(busy), .done(done), .illegal(illegal),
      .flag_e_o(flag_e_o), .flag_i_o(flag_i_o), .flag_c_o(flag_c_o),
      .flag_z_o(flag_z_o), .idx_we(idx_we), .idx_sel(idx_sel),
      .idx_wdata(idx_wdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // instr, x, y, ext, e, i, c, z, read nibble
   typedef struct packed {
      logic [12:0] op;
      logic [15:0] x;
      logic [15:0] y;
      logic [7:0]  ext;
      logic        e, i, c, z;
      logic [3:0]  rd;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{13'h10E4, 16'h1234, 16'hABCD, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 4'h9},
      '{13'h10E5, 16'h1234, 16'hABCD, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 4'h6},
      '{13'h10E6, 16'h1234, 16'hABCD, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1},
      '{13'h10E7, 16'h1234, 16'hABCD, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF},
      '{13'h10E4, 16'h1234, 16'hABCD, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 4'h8},
      '{13'h10E6, 16'h1234, 16'hABCD, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0},
      '{13'h10E5, 16'h0777, 16'hABCD, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 4'h3},
      '{13'h10E7, 16'h1234, 16'h0321, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 4'hA},
      '{13'h10E5, 16'hFFFF, 16'hABCD, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'h4},
      '{13'h10E7, 16'h1234, 16'hFFFF, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'h7},
      '{13'h10E4, 16'h0000, 16'hABCD, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 4'hE},
      '{13'h10E6, 16'h1234, 16'hABCD, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 4'h5}
   };

   task automatic drive(input vec_t v);
      instr = v.op; idx_x = v.x; idx_y = v.y; ext_val = v.ext;
      flag_e = v.e; flag_i = v.i; flag_c = v.c; flag_z = v.z;
      mem_rdata = v.rd;
   endtask

   task automatic run_vec(input vec_t v);
      logic [15:0] exp_addr;
      logic [15:0] idx;
      logic [3:0]  res;
      idx = v.op[1] ? v.y : v.x;
      if (v.e && !v.op[0]) exp_addr = v.op[1] ? {8'hFF, v.ext} : {8'h00, v.ext};
      else exp_addr = idx;
      res = {1'b0, v.rd[3:1]};
      @(negedge clk);
      drive(v);
      start = 1'b1;
      #1;
      chk(mem_addr == exp_addr, "R6/R7/R8 address cycle 1", mem_addr, exp_addr);
      chk(!mem_we && !done && !illegal, "R2 cycle 1 quiet", {mem_we, done, illegal}, 0);
      @(negedge clk);
      start = 1'b0;
      mem_rdata = ~v.rd;   // must not matter after sampling
      flag_i = ~v.i;       // nor the live I flag
      #1;
      chk(mem_we && done, "R2 cycle 2 write", {mem_we, done}, 3);
      chk(mem_addr == exp_addr, "R2 address held", mem_addr, exp_addr);
      chk(mem_wdata == res, "R3 shifted nibble", mem_wdata, res);
      chk(flag_c_o == v.rd[0], "R4 carry", flag_c_o, v.rd[0]);
      chk(flag_z_o == (res == 4'h0), "R4 zero", flag_z_o, (res == 4'h0));
      chk(flag_e_o == 1'b0 && flag_i_o == v.i, "R5 E/I", {flag_e_o, flag_i_o}, {1'b0, v.i});
      chk(idx_we == v.op[0], "R9 index write enable", idx_we, v.op[0]);
      if (v.op[0]) begin
         chk(idx_sel == v.op[1], "R9 index select", idx_sel, v.op[1]);
         chk(idx_wdata == idx + 16'd1, "R9 incremented index", idx_wdata, idx + 16'd1);
      end
      @(negedge clk);
      #1;
      chk(!done && !mem_we, "R2 back to idle", {done, mem_we}, 0);
   endtask

   task automatic try_illegal(input logic [12:0] op);
      @(negedge clk);
      instr = op; flag_e = 1'b0;
      start = 1'b1;
      #1;
      chk(illegal == 1'b1, "R1 illegal raised", illegal, 1);
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(!done && !mem_we && !idx_we && !illegal, "R1 no access", {done, mem_we, idx_we, illegal}, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R11 reset state
      start = 1'b1; instr = 13'h10E4;
      repeat (2) @(negedge clk);
      #1;
      chk(!mem_we && !done && !idx_we && !illegal, "R11 during reset",
          {mem_we, done, idx_we, illegal}, 0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!mem_we && !done && !idx_we && !illegal, "R11 after reset",
          {mem_we, done, idx_we, illegal}, 0);
      flag_e = 1; flag_i = 0; flag_c = 1; flag_z = 0;
      #1;
      chk({flag_e_o, flag_i_o, flag_c_o, flag_z_o} == 4'b1010, "R5 idle echo",
          {flag_e_o, flag_i_o, flag_c_o, flag_z_o}, 4'b1010);

      for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

      // R1 neighbouring words
      try_illegal(13'h10E3);
      try_illegal(13'h10E8);
      try_illegal(13'h00E4);
      try_illegal(13'h1FE4);

      // R10 start held into cycle 2 is ignored
      @(negedge clk);
      drive(VECS[0]);
      flag_e = 1'b0;
      start = 1'b1;
      @(negedge clk);
      #1;
      chk(done, "R10 cycle 2 reached", done, 1);
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(!done && !mem_we && !busy, "R10 no second access", {done, mem_we, busy}, 0);
      @(negedge clk);
      #1;
      chk(!done && !mem_we, "R10 stays idle", {done, mem_we}, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule